// File: doc/BRIEF.md
# Micro-op Unlamination Splitter

This block sits between a micro-op queue and the issue/rename stage of an out-of-order core model. Each cycle it may accept one fused micro-op over a valid/ready handshake. The micro-op arrives with a class, a flag for base-plus-scaled-index addressing, a flag for the two-operand destructive (read-modify-write) form, and a payload. The block then decides whether the micro-op has to be broken in two before rename. When it does, two simple micro-ops leave on consecutive output handshakes, so each takes its own issue slot downstream, and the input is back-pressured until the second one has been loaded. Every other micro-op leaves unchanged as a single entry.

Only indexed addressing causes a split. A load combined with a computation becomes a load half followed by a compute half. A store becomes a store-address half followed by a store-data half. A global relax bit lets an indexed load-plus-compute stay fused when it has the two-operand destructive form; a three-operand form is split even then. Both halves carry the same tag and a first/second bit, so later logic can pair them. Two running counters report how many micro-ops were accepted and how many were emitted.

Top module: `uop_split`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and in_count and out_count are 0.
- R2: A micro-op of class ALU (in_cls=0) or plain load (in_cls=1) is emitted once with out_kind=0 (whole), whatever in_indexed is.
- R3: A load-plus-compute micro-op (in_cls=2) with in_indexed=0 is emitted once with out_kind=0.
- R4: A load-plus-compute micro-op with in_indexed=1 that is not kept fused under R6 is emitted as two micro-ops. The first has out_kind=1 (load) and the second has out_kind=2 (compute).
- R5: A store (in_cls=3) with in_indexed=1 is emitted as out_kind=3 (store address) followed by out_kind=4 (store data). A store with in_indexed=0 is emitted once with out_kind=0.
- R6: With relax_en=1 at acceptance, an indexed load-plus-compute micro-op with in_rmw2=1 is emitted once with out_kind=0. With in_rmw2=0, or with relax_en=0, it is split as in R4.
- R7: Both halves of a split carry out_split=1 and the same out_tag; out_second is 0 on the first half and 1 on the second. A whole micro-op carries out_split=0 and out_second=0. out_tag equals the number of micro-ops accepted before this one, modulo 2^TAGW.
- R8: In the cycle after a splittable micro-op is accepted, and for as long as its first half waits on the output, in_ready is 0.
- R9: While out_valid=1 and out_ready=0, every output field stays stable on the next cycle. No micro-op or half is dropped or emitted twice, and output order follows input order.
- R10: in_count counts input handshakes and out_count counts output handshakes since reset.
- R11: Every emitted micro-op, each half included, carries the input payload and class unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| relax_en | input | 1 | Keep indexed two-operand destructive load-compute fused |
| in_valid | input | 1 | Input micro-op valid |
| in_ready | output | 1 | Input can be accepted |
| in_cls | input | 2 | Class: 0 ALU, 1 load, 2 load+compute, 3 store |
| in_indexed | input | 1 | Base plus scaled index address |
| in_rmw2 | input | 1 | Two-operand form, destination is also a source |
| in_payload | input | PAYW | Opaque micro-op contents |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Issue stage takes the output |
| out_cls | output | 2 | Class copied from input |
| out_kind | output | 3 | 0 whole, 1 load half, 2 compute half, 3 store address, 4 store data |
| out_split | output | 1 | Belongs to a split pair |
| out_second | output | 1 | Second half of a pair |
| out_tag | output | TAGW | Pairing tag |
| out_payload | output | PAYW | Payload copied from input |
| in_count | output | CNTW | Accepted micro-ops |
| out_count | output | CNTW | Emitted micro-ops |

## Verification
An input accepted at a clock edge is visible on the outputs right after that edge. The second half of a split follows on the edge where the first half is taken. The counters show a handshake one edge after it happens. The bench drives stimulus on the falling edge and lets it settle. It then decides which handshakes the next rising edge will make and pops its expected-output queue for them, so each comparison lines up with the edge that moves data rather than with a fixed delay. The in_ready, stability and counter checks look at values one edge after the recorded event.

// File: rtl/uop_split_pkg.sv
package uop_split_pkg;

    typedef enum logic [1:0] {
        UC_ALU   = 2'd0,
        UC_LOAD  = 2'd1,
        UC_LDOP  = 2'd2,
        UC_STORE = 2'd3
    } uclass_e;

    typedef enum logic [2:0] {
        UK_WHOLE  = 3'd0,
        UK_LDHALF = 3'd1,
        UK_OPHALF = 3'd2,
        UK_STADDR = 3'd3,
        UK_STDATA = 3'd4
    } ukind_e;

    typedef struct packed {
        uclass_e cls;
        ukind_e  kind;
        logic    split;
        logic    second;
    } uhdr_t;

    // Split rule: only indexed addressing splits; relax keeps 2-op destructive load-compute fused
    function automatic logic must_split(uclass_e c, logic idx, logic rmw2, logic relax);
        logic r;
        r = 1'b0;
        if (idx) begin
            case (c)
                UC_LDOP:  r = !(relax && rmw2);
                UC_STORE: r = 1'b1;
                default:  r = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic ukind_e lead_kind(uclass_e c, logic split);
        ukind_e k;
        k = UK_WHOLE;
        if (split) k = (c == UC_STORE) ? UK_STADDR : UK_LDHALF;
        return k;
    endfunction

    function automatic ukind_e tail_kind(uclass_e c);
        return (c == UC_STORE) ? UK_STDATA : UK_OPHALF;
    endfunction

endpackage

// File: rtl/uop_split_decide.sv
module uop_split_decide
    import uop_split_pkg::*;
(
    input  uclass_e cls,
    input  logic    indexed,
    input  logic    rmw2,
    input  logic    relax,
    output uhdr_t   lead_hdr,
    output uhdr_t   tail_hdr
);
    logic split;

    always_comb begin
        split           = must_split(cls, indexed, rmw2, relax);
        lead_hdr.cls    = cls;
        lead_hdr.kind   = lead_kind(cls, split);
        lead_hdr.split  = split;
        lead_hdr.second = 1'b0;
        tail_hdr.cls    = cls;
        tail_hdr.kind   = tail_kind(cls);
        tail_hdr.split  = 1'b1;
        tail_hdr.second = 1'b1;
    end
endmodule

// File: rtl/uop_split_stage.sv
module uop_split_stage
    import uop_split_pkg::*;
#(
    parameter int PAYW = 16,
    parameter int TAGW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  uhdr_t           lead_hdr,
    input  uhdr_t           tail_hdr,
    input  logic [PAYW-1:0] in_payload,
    input  logic [TAGW-1:0] in_tag,
    output logic            out_valid,
    input  logic            out_ready,
    output uhdr_t           out_hdr,
    output logic [TAGW-1:0] out_tag,
    output logic [PAYW-1:0] out_payload
);
    logic            ov;
    logic            pend;
    uhdr_t           cur_hdr;
    uhdr_t           pend_hdr;
    logic [TAGW-1:0] cur_tag;
    logic [PAYW-1:0] cur_pay;
    logic            advance;

    assign advance  = !ov || out_ready;
    assign in_ready = advance && !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov       <= 1'b0;
            pend     <= 1'b0;
            cur_hdr  <= '0;
            pend_hdr <= '0;
            cur_tag  <= '0;
            cur_pay  <= '0;
        end else if (advance) begin
            if (pend) begin
                ov      <= 1'b1;
                cur_hdr <= pend_hdr;
                pend    <= 1'b0;
            end else if (in_valid) begin
                ov       <= 1'b1;
                cur_hdr  <= lead_hdr;
                cur_tag  <= in_tag;
                cur_pay  <= in_payload;
                pend     <= lead_hdr.split;
                pend_hdr <= tail_hdr;
            end else begin
                ov <= 1'b0;
            end
        end
    end

    assign out_valid   = ov;
    assign out_hdr     = cur_hdr;
    assign out_tag     = cur_tag;
    assign out_payload = cur_pay;
endmodule

// File: rtl/uop_split_count.sv
module uop_split_count #(
    parameter int CNTW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_fire,
    input  logic            out_fire,
    output logic [CNTW-1:0] in_count,
    output logic [CNTW-1:0] out_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_count  <= '0;
            out_count <= '0;
        end else begin
            if (in_fire)  in_count  <= in_count + 1'b1;
            if (out_fire) out_count <= out_count + 1'b1;
        end
    end
endmodule

// File: rtl/uop_split.sv
module uop_split
    import uop_split_pkg::*;
#(
    parameter int PAYW = 16,
    parameter int TAGW = 4,
    parameter int CNTW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            relax_en,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_cls,
    input  logic            in_indexed,
    input  logic            in_rmw2,
    input  logic [PAYW-1:0] in_payload,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [1:0]      out_cls,
    output logic [2:0]      out_kind,
    output logic            out_split,
    output logic            out_second,
    output logic [TAGW-1:0] out_tag,
    output logic [PAYW-1:0] out_payload,
    output logic [CNTW-1:0] in_count,
    output logic [CNTW-1:0] out_count
);
    uhdr_t lead_hdr;
    uhdr_t tail_hdr;
    uhdr_t out_hdr;
    logic  rdy;

    uop_split_decide u_decide (
        .cls      (uclass_e'(in_cls)),
        .indexed  (in_indexed),
        .rmw2     (in_rmw2),
        .relax    (relax_en),
        .lead_hdr (lead_hdr),
        .tail_hdr (tail_hdr)
    );

    uop_split_stage #(.PAYW(PAYW), .TAGW(TAGW)) u_stage (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (rdy),
        .lead_hdr    (lead_hdr),
        .tail_hdr    (tail_hdr),
        .in_payload  (in_payload),
        .in_tag      (in_count[TAGW-1:0]),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_hdr     (out_hdr),
        .out_tag     (out_tag),
        .out_payload (out_payload)
    );

    uop_split_count #(.CNTW(CNTW)) u_count (
        .clk       (clk),
        .rst       (rst),
        .in_fire   (in_valid && rdy),
        .out_fire  (out_valid && out_ready),
        .in_count  (in_count),
        .out_count (out_count)
    );

    assign in_ready   = rdy;
    assign out_cls    = out_hdr.cls;
    assign out_kind   = out_hdr.kind;
    assign out_split  = out_hdr.split;
    assign out_second = out_hdr.second;
endmodule

// File: rtl/uop_split_chk.sv
module uop_split_chk #(
    parameter int PAYW = 16,
    parameter int TAGW = 4,
    parameter int CNTW = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [1:0]      out_cls,
    input logic [2:0]      out_kind,
    input logic            out_split,
    input logic            out_second,
    input logic [TAGW-1:0] out_tag,
    input logic [PAYW-1:0] out_payload,
    input logic [CNTW-1:0] in_count,
    input logic [CNTW-1:0] out_count
);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_kind)
            && $stable(out_tag) && $stable(out_second) && $stable(out_cls));

    // R7
    pair_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_split && !out_second |=>
            out_valid && out_second && out_split && out_tag == $past(out_tag)
            && out_payload == $past(out_payload));

    // R8
    pend_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_split && !out_second |-> !in_ready);

    // R7
    whole_flags_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_split |-> !out_second && out_kind == 3'd0);

    // R4
    ldop_kind_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_split && out_cls == 2'd2 |-> out_kind == (out_second ? 3'd2 : 3'd1));

    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, out_count} <= {in_count, 1'b0});
endmodule

bind uop_split uop_split_chk #(.PAYW(PAYW), .TAGW(TAGW), .CNTW(CNTW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_cls     (out_cls),
    .out_kind    (out_kind),
    .out_split   (out_split),
    .out_second  (out_second),
    .out_tag     (out_tag),
    .out_payload (out_payload),
    .in_count    (in_count),
    .out_count   (out_count)
);

// File: tb/uop_split_test.sv
module uop_split_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAYW = 16;
    localparam int TAGW = 4;
    localparam int CNTW = 32;
    localparam int NCYC = 4000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            relax_en = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [1:0]      in_cls = '0;
    logic            in_indexed = 1'b0;
    logic            in_rmw2 = 1'b0;
    logic [PAYW-1:0] in_payload = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [1:0]      out_cls;
    logic [2:0]      out_kind;
    logic            out_split;
    logic            out_second;
    logic [TAGW-1:0] out_tag;
    logic [PAYW-1:0] out_payload;
    logic [CNTW-1:0] in_count;
    logic [CNTW-1:0] out_count;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uop_split #(.PAYW(PAYW), .TAGW(TAGW), .CNTW(CNTW)) uut (.*);

    typedef struct {
        logic [1:0]      cls;
        logic [2:0]      kind;
        logic            split;
        logic            second;
        logic [TAGW-1:0] tag;
        logic [PAYW-1:0] pay;
        int              req;
    } exp_t;

    exp_t exq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference split rule from R2..R6
    function automatic bit ref_split(logic [1:0] c, logic idx, logic rmw, logic rlx);
        if (!idx) return 1'b0;
        if (c == 2'd3) return 1'b1;                  // R5
        if (c == 2'd2) return !(rlx && rmw);          // R4, R6
        return 1'b0;                                  // R2
    endfunction

    function automatic int ref_req(logic [1:0] c, logic idx, logic rmw, logic rlx);
        if (c < 2'd2) return 2;                       // R2
        if (c == 2'd3) return 5;                      // R5
        if (!idx) return 3;                           // R3
        if (rlx && rmw) return 6;                     // R6
        return 4;                                     // R4
    endfunction

    task automatic push_exp(logic [1:0] c, logic idx, logic rmw, logic rlx,
                            logic [PAYW-1:0] p, logic [TAGW-1:0] t);
        exp_t e;
        bit sp;
        sp = ref_split(c, idx, rmw, rlx);
        e.cls = c; e.pay = p; e.tag = t; e.split = sp; e.second = 1'b0;
        e.req = ref_req(c, idx, rmw, rlx);
        e.kind = !sp ? 3'd0 : (c == 2'd3 ? 3'd3 : 3'd1);
        exq.push_back(e);
        if (sp) begin
            e.second = 1'b1;
            e.kind = (c == 2'd3) ? 3'd4 : 3'd2;
            exq.push_back(e);
        end
    endtask

    // directed corner list: {cls, idx, rmw2, relax}
    logic [4:0] dir_ops [14] = '{
        5'b00_1_0_0, 5'b01_1_0_0, 5'b10_0_0_0, 5'b10_1_0_0, 5'b10_1_1_0,
        5'b10_1_1_1, 5'b10_1_0_1, 5'b11_1_0_0, 5'b11_0_0_0, 5'b11_1_1_1,
        5'b01_0_1_1, 5'b10_0_1_1, 5'b10_1_1_1, 5'b11_1_0_0};

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int acc = 0;
        int popped = 0;
        int dir_i = 0;
        bit prev_stall = 0;
        bit prev_split_acc = 0;
        logic [PAYW+TAGW+6:0] saved = '0;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        check(in_count == 0 && out_count == 0, "R1", "counters", in_count + out_count, 0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            // R10 counters reflect handshakes of earlier edges
            check(in_count == CNTW'(acc), "R10", "in_count", in_count, acc);
            check(out_count == CNTW'(popped), "R10", "out_count", out_count, popped);
            // R9 stability after a stalled cycle
            if (prev_stall)
                check({out_valid, out_cls, out_kind, out_second, out_tag, out_payload} == saved,
                      "R9", "held output", {out_valid, out_cls, out_kind, out_second, out_tag, out_payload}, saved);
            // R8 input blocked while second half pending
            if (prev_split_acc)
                check(in_ready == 1'b0, "R8", "in_ready after split", in_ready, 0);

            // drive new stimulus unless an offered input is still waiting
            if (!(in_valid && !in_ready)) begin
                if (cyc < 60) begin
                    in_valid = (cyc % 3) != 2;
                    if (in_valid) begin
                        {in_cls, in_indexed, in_rmw2, relax_en} = dir_ops[dir_i % 14];
                        dir_i++;
                    end
                end else begin
                    in_valid = ($urandom % 4) != 0;
                    in_cls = 2'($urandom);
                    in_indexed = 1'($urandom);
                    in_rmw2 = 1'($urandom);
                    relax_en = 1'($urandom);
                end
                in_payload = PAYW'($urandom);
            end
            out_ready = (cyc < 60) ? ((cyc % 5) != 4) : (($urandom % 3) != 0);
            #1;

            // output handshake at next edge: compare with expected head
            if (out_valid && out_ready) begin
                if (exq.size() == 0) begin
                    check(1'b0, "R9", "extra output", out_kind, 0);
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    check(out_kind == e.kind && out_split == e.split, $sformatf("R%0d", e.req),
                          "kind/split", {out_kind, out_split}, {e.kind, e.split});
                    // R7 tag and half marker
                    check(out_tag == e.tag && out_second == e.second, "R7", "tag/second",
                          {out_tag, out_second}, {e.tag, e.second});
                    // R11 payload and class carried
                    check(out_payload == e.pay && out_cls == e.cls, "R11", "payload/cls",
                          {out_cls, out_payload}, {e.cls, e.pay});
                end
                popped++;
            end
            prev_split_acc = 0;
            if (in_valid && in_ready) begin
                push_exp(in_cls, in_indexed, in_rmw2, relax_en, in_payload, TAGW'(acc));
                prev_split_acc = ref_split(in_cls, in_indexed, in_rmw2, relax_en);
                acc++;
            end
            prev_stall = out_valid && !out_ready;
            saved = {out_valid, out_cls, out_kind, out_second, out_tag, out_payload};

            @(posedge clk);
            @(negedge clk);
        end

        // drain and confirm nothing was lost (R9)
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (out_valid) begin
                if (exq.size() != 0) begin
                    exp_t e;
                    e = exq.pop_front();
                    check(out_kind == e.kind && out_payload == e.pay, "R9", "drain",
                          {out_kind, out_payload}, {e.kind, e.pay});
                end
                popped++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        check(exq.size() == 0, "R9", "lost outputs", exq.size(), 0);
        check(out_count == CNTW'(popped) && in_count == CNTW'(acc), "R10", "final counts",
              out_count, popped);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule